// File: doc/BRIEF.md
# Flash Busy Status Reporter

This block sits in a byte-wide parallel flash device model, next to the command decoder and the array read path. When the decoder has taken in the last write of a program or erase sequence, it sends a one-cycle start pulse. With the pulse it gives the operation type and, for a program, the byte being written. The block then stays busy for a number of clock cycles. Three cycle-count inputs set that number, one for each class of operation, and the operation type picks which one applies.

While the block is busy, every read returns a status byte in place of array contents:
- Bit 7 is a polarity flag. It is the inverse of the programmed byte's top bit for a program, and 0 for any erase.
- Bit 6 is a toggle bit. It flips once on each read strobe.
- Bits 5 to 0 read as 0.

While the block is idle, array data passes through untouched. Start pulses that arrive during an operation are dropped. When the count runs out, busy falls and a one-cycle done pulse goes to the rest of the device model.

Top module: `flash_busy_status`

## Requirements
- R1: After reset, busy_o and done_o are 0, and rd_data_o equals array_data_i.
- R2: While busy_o is 0, rd_data_o equals array_data_i for any byte value.
- R3: While a program is active (op_i = 2'b00 at start), rd_data_o[7] is the inverse of bit 7 of the written byte captured at start.
- R4: While an erase is active, rd_data_o[7] is 0. The erase codes are op_i = 2'b01 (sector), 2'b10 (block) and 2'b11 (chip).
- R5: While busy, rd_data_o[6] shows a toggle state. That state flips after each cycle in which rd_strobe_i is 1 and holds in cycles without a strobe. It is 0 after reset.
- R6: While busy, rd_data_o[5:0] reads as 0.
- R7: An accepted start drives busy_o to 1 from the next cycle. busy_o then stays 1 for N cycles, where N is prog_cycles_i for a program, erase_cycles_i for a sector or block erase, and chip_cycles_i for a chip erase. A count of 0 acts as 1.
- R8: done_o is 1 for exactly one cycle: the first cycle after busy_o falls. From that cycle on, reads return array data.
- R9: A start pulse during busy is ignored. It changes neither the remaining duration nor the latched bit 7 value.
- R10: Read strobes while idle do not change the toggle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse from the command decoder |
| op_i | input | 2 | Operation: 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| wdata_i | input | 8 | Byte being programmed (sampled at start) |
| prog_cycles_i | input | CNT_W | Busy length for program |
| erase_cycles_i | input | CNT_W | Busy length for sector or block erase |
| chip_cycles_i | input | CNT_W | Busy length for chip erase |
| rd_strobe_i | input | 1 | One cycle per array read |
| array_data_i | input | 8 | Data from the array read path |
| rd_data_o | output | 8 | Byte returned to the reader |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CNT_W = 6. This keeps every busy window short and makes the full-scale count of 63 reachable, so the widest chip erase runs within the bench's time budget. The bench covers the zero-count edge case, a count that ends while reads are still arriving, and a start that arrives mid-operation. All three run next to ordinary windows of 7 to 12 cycles. Toggle parity carries across operations and idle strobes, so the bench can check its value at the start of each operation and not only how it alternates.

// File: rtl/fbs_pkg.sv
// Shared types for the flash busy status reporter.
package fbs_pkg;
    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_SECT  = 2'b01,
        OP_BLOCK = 2'b10,
        OP_CHIP  = 2'b11
    } fbs_op_e;

    localparam int BYTE_W   = 8;
    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;
endpackage

// File: rtl/fbs_duration_sel.sv
// Picks the busy length for an operation class.
// Assumes: sector and block erase share one count.
module fbs_duration_sel #(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       op_i,
    input  logic [CNT_W-1:0] prog_cycles_i,
    input  logic [CNT_W-1:0] erase_cycles_i,
    input  logic [CNT_W-1:0] chip_cycles_i,
    output logic [CNT_W-1:0] cycles_o
);
    import fbs_pkg::*;

    // Map the operation code to its cycle count.
    always_comb begin
        unique case (fbs_op_e'(op_i))
            OP_PROG:          cycles_o = prog_cycles_i;
            OP_SECT, OP_BLOCK: cycles_o = erase_cycles_i;
            default:          cycles_o = chip_cycles_i;
        endcase
    end
endmodule

// File: rtl/fbs_busy_timer.sv
// Down-counter that holds busy for max(N,1) cycles after an accepted start
// and then pulses done once. Assumes: start while busy is ignored.
module fbs_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    // A start is taken only when idle.
    assign accept_o = start_i && !busy_o;

    // Load, count down and end the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept_o) begin
                busy_o   <= 1'b1;
                remain_q <= (load_i == '0) ? '0 : load_i - ONE;
            end else if (busy_o) begin
                if (remain_q == '0) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    remain_q <= remain_q - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/fbs_toggle.sv
// Toggle-bit state: flips once per read strobe taken while busy and is
// kept between reads and across operations. Assumes one strobe per read.
module fbs_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic rd_strobe_i,
    output logic tgl_o
);
    // Advance on busy reads only.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tgl_o <= 1'b0;
        else if (busy_i && rd_strobe_i) tgl_o <= ~tgl_o;
    end
endmodule

// File: rtl/fbs_status_fmt.sv
// Latches the polarity flag at start and forms the read byte: status while
// busy, array data otherwise. Assumes BYTE_W is 8.
module fbs_status_fmt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic [1:0] op_i,
    input  logic [7:0] wdata_i,
    input  logic       busy_i,
    input  logic       tgl_i,
    input  logic [7:0] array_data_i,
    output logic [7:0] rd_data_o
);
    import fbs_pkg::*;

    logic poll_q;
    logic [BYTE_W-1:0] status;

    // Capture the bit 7 value to report for this operation.
    always_ff @(posedge clk) begin
        if (!rst_n)        poll_q <= 1'b1;
        else if (accept_i) poll_q <= (fbs_op_e'(op_i) == OP_PROG) ? ~wdata_i[POLL_BIT] : 1'b0;
    end

    // Assemble the status byte and choose the output source.
    always_comb begin
        status           = '0;
        status[POLL_BIT] = poll_q;
        status[TGL_BIT]  = tgl_i;
        rd_data_o        = busy_i ? status : array_data_i;
    end
endmodule

// File: rtl/flash_busy_status.sv
// End-of-write status reporter for a byte-wide flash model. Starts on a
// decoder pulse, stays busy for a per-operation count and substitutes
// polling and toggle flags for array reads meanwhile.
module flash_busy_status #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [7:0]       wdata_i,
    input  logic [CNT_W-1:0] prog_cycles_i,
    input  logic [CNT_W-1:0] erase_cycles_i,
    input  logic [CNT_W-1:0] chip_cycles_i,
    input  logic             rd_strobe_i,
    input  logic [7:0]       array_data_i,
    output logic [7:0]       rd_data_o,
    output logic             busy_o,
    output logic             done_o
);
    logic [CNT_W-1:0] load_val;
    logic             accept;
    logic             tgl;

    fbs_duration_sel #(.CNT_W(CNT_W)) u_sel (
        .op_i(op_i), .prog_cycles_i(prog_cycles_i),
        .erase_cycles_i(erase_cycles_i), .chip_cycles_i(chip_cycles_i),
        .cycles_o(load_val)
    );

    fbs_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_val),
        .accept_o(accept), .busy_o(busy_o), .done_o(done_o)
    );

    fbs_toggle u_tgl (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_o),
        .rd_strobe_i(rd_strobe_i), .tgl_o(tgl)
    );

    fbs_status_fmt u_fmt (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .op_i(op_i),
        .wdata_i(wdata_i), .busy_i(busy_o), .tgl_i(tgl),
        .array_data_i(array_data_i), .rd_data_o(rd_data_o)
    );
endmodule

// File: rtl/fbs_checker.sv
// Port-level properties of the busy status reporter.
module fbs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       rd_strobe_i,
    input logic       busy_o,
    input logic       done_o,
    input logic [7:0] rd_data_o
);
    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (busy_o || done_o));
    // R6
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rd_data_o[5:0] == 6'd0));
    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rd_strobe_i) |=> (!busy_o || rd_data_o[6] != $past(rd_data_o[6])));
    // R5
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rd_strobe_i) |=> (!busy_o || $stable(rd_data_o[6])));
endmodule

bind flash_busy_status fbs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_strobe_i(rd_strobe_i),
    .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o)
);

// File: tb/flash_busy_status_tb.sv
`timescale 1ns/1ps
module flash_busy_status_tb;
    localparam int CW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] op_i = 2'b00;
    logic [7:0] wdata_i = 8'h00;
    logic [CW-1:0] prog_c = '0, erase_c = '0, chip_c = '0;
    logic rd_strobe_i = 1'b0;
    logic [7:0] array_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic busy_o, done_o;

    int n_tests = 0, n_fail = 0;
    int busy_cyc = 0, done_cnt = 0;
    bit tgl = 1'b0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    flash_busy_status #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .wdata_i(wdata_i), .prog_cycles_i(prog_c), .erase_cycles_i(erase_c),
        .chip_cycles_i(chip_c), .rd_strobe_i(rd_strobe_i),
        .array_data_i(array_data_i), .rd_data_o(rd_data_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected byte for every read strobe.
    always @(negedge clk) begin
        if (busy_o) busy_cyc++;
        if (done_o) done_cnt++;
        if (rd_strobe_i && rst_n) begin
            if (exp_q.size() == 0) check(1'b0, "queue", 0, 1);
            else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(rd_data_o == e, r, rd_data_o, e);
            end
        end
    end

    // Driver: one-cycle read with its expected result.
    task automatic do_read(input logic [7:0] arr, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        array_data_i = arr;
        rd_strobe_i  = 1'b1;
        exp_q.push_back(exp);
        req_q.push_back(req);
        @(posedge clk); #1;
        rd_strobe_i = 1'b0;
    endtask

    // Busy read: status byte from the bench's own toggle model.
    task automatic busy_read(input bit b7, input string req);
        do_read(8'h3C, {b7, tgl, 6'b0}, req);
        tgl = ~tgl;
    endtask

    task automatic start_op(input logic [1:0] op, input logic [7:0] wd);
        @(posedge clk); #1;
        busy_cyc = 0; done_cnt = 0;
        op_i = op; wdata_i = wd; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic finish_op(input int n, input string req);
        while (busy_o) begin @(posedge clk); #1; end
        @(negedge clk); @(negedge clk);
        check(busy_cyc == n, req, busy_cyc, n);
        check(done_cnt == 1, "R8", done_cnt, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 0, "R1", busy_o, 0);
        check(done_o == 0, "R1", done_o, 0);
        do_read(8'h5A, 8'h5A, "R1");
        // R2 idle pass-through, R10 idle strobes leave toggle alone
        do_read(8'h00, 8'h00, "R2");
        do_read(8'hFF, 8'hFF, "R2");
        do_read(8'hA5, 8'hA5, "R10");

        // R3 program, written MSB 0 -> bit7 1; R5 toggle from 0
        prog_c = 6'd12; erase_c = 6'd9; chip_c = 6'd63;
        start_op(2'b00, 8'h3C);
        busy_read(1'b1, "R3");
        busy_read(1'b1, "R5");
        busy_read(1'b1, "R5");
        repeat (2) @(posedge clk);
        busy_read(1'b1, "R5");
        finish_op(12, "R7");
        do_read(8'h3C, 8'h3C, "R8");

        // R7 zero count behaves as one cycle; R3 MSB 1 -> bit7 0
        prog_c = 6'd0;
        start_op(2'b00, 8'h80);
        check(rd_data_o[7] == 1'b0, "R3", rd_data_o[7], 0);
        finish_op(1, "R7");

        // R4 sector erase
        start_op(2'b01, 8'hFF);
        busy_read(1'b0, "R4");
        busy_read(1'b0, "R6");
        finish_op(9, "R7");

        // R4 chip erase at full-scale count
        start_op(2'b11, 8'hFF);
        busy_read(1'b0, "R4");
        finish_op(63, "R7");
        do_read(8'hFF, 8'hFF, "R8");

        // R9 start during program ignored
        prog_c = 6'd10; chip_c = 6'd40;
        start_op(2'b00, 8'h00);
        @(posedge clk); #1;
        op_i = 2'b11; wdata_i = 8'h80; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        busy_read(1'b1, "R9");
        finish_op(10, "R9");

        // R10 idle strobes, then toggle continues from its kept value
        do_read(8'h11, 8'h11, "R10");
        do_read(8'h22, 8'h22, "R10");
        erase_c = 6'd7;
        start_op(2'b10, 8'h00);
        busy_read(1'b0, "R10");
        busy_read(1'b0, "R4");
        finish_op(7, "R7");

        repeat (2) @(posedge clk);
        check(exp_q.size() == 0, "queue", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule